// File: doc/BRIEF.md
# Accumulator ALU with condition flags

This block is the arithmetic core of a small 16-bit signal processor. It holds a 32-bit accumulator split into a high half and a low half. On each cycle that an operation is presented, it applies one of a fixed set of operations. Each operation combines a 16-bit operand with the accumulator, and most of them update a status word that holds four flags.

A separate path tests the branch conditions. It compares one selected flag against a polarity bit taken from the opcode, and it reports an error pulse when the condition code is one it does not support.

A third path is a signed fractional multiplier. It forms twice the product of two 16-bit inputs into a 32-bit product register. The instruction sequencer outside the block supplies the operation code, the operand, the multiplier inputs and the condition field, and it reads back the accumulator, the flags, the product and the condition result.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and directly after it, the accumulator, the status word and the product are all zero, and `cond_err` is low.
- R2: With `op_valid` high and `op_code`=3 (add), the high half becomes (high + operand) mod 2^16 at the next clock edge, and the low half is unchanged.
- R3: With `op_code`=4 (subtract), the high half becomes (high - operand) mod 2^16, and the low half is unchanged.
- R4: With `op_code`=5 (compare), the accumulator does not change, but the flags are updated as for a subtraction.
- R5: After add, subtract or compare, L (status bit 12) and V (bit 14) are 0. Z (bit 13) is 1 when the 16-bit result is zero. N (bit 15) equals result bit 15 when Z is 0, and N is 0 when Z is 1.
- R6: With `op_code`=6 (AND), the accumulator becomes acc & {operand, 16'h0000}, so the low half is cleared.
- R7: With `op_code`=7 (OR), the accumulator becomes acc | {operand, 16'h0000}. With `op_code`=8 (XOR), it becomes acc ^ {operand, 16'h0000}. In both cases the low half is unchanged.
- R8: After AND, OR or XOR, Z is 1 when the whole 32-bit result is zero. N equals result bit 31 when Z is 0, and N is 0 when Z is 1. L and V hold their previous values.
- R9: `op_code`=1 loads the operand into the high half, and `op_code`=2 loads the operand into the low half. Neither load changes the status word or the other half.
- R10: When `op_valid` is low, or when `op_code` is 0 or a value above 8, the accumulator and the status word hold their values.
- R11: `cond_true` is combinational and depends on `cond_sel`. For `cond_sel`=0 it is always 1. For `cond_sel`=5 it is 1 when Z equals `cond_bit`. For `cond_sel`=7 it is 1 when N equals `cond_bit`.
- R12: Any other `cond_sel` value gives `cond_true`=0. In that case `cond_err` is 1 whenever `cond_check` is high.
- R13: When `mul_en` is high at a clock edge, `product` becomes (signed X × signed Y × 2) mod 2^32. When `mul_en` is low, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Applies `op_code` at this edge |
| op_code | input | 4 | Operation select (0 none, 1 load high, 2 load low, 3 add, 4 sub, 5 cmp, 6 and, 7 or, 8 xor) |
| operand | input | 16 | Operand |
| cond_sel | input | 4 | Condition code |
| cond_bit | input | 1 | Flag polarity to compare against |
| cond_check | input | 1 | A condition is being evaluated this cycle |
| mul_en | input | 1 | Load the product register |
| mul_x | input | 16 | Multiplier input X, signed |
| mul_y | input | 16 | Multiplier input Y, signed |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word, N/V/Z/L in bits 15..12, other bits 0 |
| product | output | 32 | Product register |
| cond_true | output | 1 | Condition result |
| cond_err | output | 1 | Unsupported condition while `cond_check` is high |

## Verification
An accumulator half that is updated wrongly appears on `acc` one edge after the operation that caused it. A flag that is stale or computed from the wrong width shows up in two places: on `status` after that same edge, and at once in `cond_true` when a Z or N condition is then tested against it. Directed cases target the results where the two flag widths differ, such as a zero high half with a nonzero low half, and a high half that wraps to zero after an add. A fault in the product path appears on `product` one edge after `mul_en`, and the edge values -32768 × -32768 and a negative times a positive exercise the sign and wrap behaviour.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_LDH  = 4'd1,
    OP_LDL  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } alu_op_e;

  // flag vector layout {N, V, Z, L}; placed at status[15:12]
  localparam int FL_L = 0;
  localparam int FL_Z = 1;
  localparam int FL_V = 2;
  localparam int FL_N = 3;
  localparam int STATUS_W = 16;
  localparam int FLAG_LSB = 12;

  localparam logic [3:0] CC_ALWAYS = 4'h0;
  localparam logic [3:0] CC_ZERO   = 4'h5;
  localparam logic [3:0] CC_NEG    = 4'h7;
endpackage

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [ACC_W-1:0]  acc_q,
  input  logic [3:0]        flags_q,
  output logic [ACC_W-1:0]  acc_d,
  output logic [3:0]        flags_d
);
  logic [DATA_W-1:0] hi, lo, sum, dif, ar;
  logic [ACC_W-1:0]  wide, lres;

  assign hi   = acc_q[ACC_W-1:DATA_W];
  assign lo   = acc_q[DATA_W-1:0];
  assign sum  = hi + operand;
  assign dif  = hi - operand;
  assign wide = {operand, {DATA_W{1'b0}}};

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    ar      = sum;
    lres    = acc_q;
    unique case (op_code)
      OP_LDH: acc_d = {operand, lo};
      OP_LDL: acc_d = {hi, operand};
      OP_ADD, OP_SUB, OP_CMP: begin
        ar = (op_code == OP_ADD) ? sum : dif;
        if (op_code != OP_CMP) acc_d = {ar, lo};
        flags_d        = 4'b0000;
        flags_d[FL_Z]  = (ar == '0);
        flags_d[FL_N]  = (ar != '0) && ar[DATA_W-1];
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op_code == OP_AND)     lres = acc_q & wide;
        else if (op_code == OP_OR) lres = acc_q | wide;
        else                       lres = acc_q ^ wide;
        acc_d         = lres;
        flags_d[FL_Z] = (lres == '0);
        flags_d[FL_N] = (lres != '0) && lres[ACC_W-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
  import acc_alu_pkg::*;
(
  input  logic [3:0] cond_sel,
  input  logic       cond_bit,
  input  logic       cond_check,
  input  logic       flag_z,
  input  logic       flag_n,
  output logic       cond_true,
  output logic       cond_err
);
  always_comb begin
    cond_true = 1'b0;
    cond_err  = 1'b0;
    unique case (cond_sel)
      CC_ALWAYS: cond_true = 1'b1;
      CC_ZERO:   cond_true = (flag_z == cond_bit);
      CC_NEG:    cond_true = (flag_n == cond_bit);
      default:   cond_err  = cond_check;
    endcase
  end
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mul_en,
  input  logic [DATA_W-1:0] mul_x,
  input  logic [DATA_W-1:0] mul_y,
  output logic [ACC_W-1:0]  product
);
  logic signed [ACC_W-1:0] xs, ys, prod_raw;
  logic [ACC_W-1:0]        prod_d, prod_q;

  assign xs       = ACC_W'($signed(mul_x));
  assign ys       = ACC_W'($signed(mul_y));
  assign prod_raw = xs * ys;

  always_comb begin
    prod_d = prod_q;
    if (mul_en) prod_d = {prod_raw[ACC_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign product = prod_q;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        cond_sel,
  input  logic              cond_bit,
  input  logic              cond_check,
  input  logic              mul_en,
  input  logic [DATA_W-1:0] mul_x,
  input  logic [DATA_W-1:0] mul_y,
  output logic [ACC_W-1:0]  acc,
  output logic [15:0]       status,
  output logic [ACC_W-1:0]  product,
  output logic              cond_true,
  output logic              cond_err
);
  logic [ACC_W-1:0] acc_q, acc_d, acc_exec;
  logic [3:0]       flags_q, flags_d, flags_exec;

  acc_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .op_code (op_code),
    .operand (operand),
    .acc_q   (acc_q),
    .flags_q (flags_q),
    .acc_d   (acc_exec),
    .flags_d (flags_exec)
  );

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    if (op_valid) begin
      acc_d   = acc_exec;
      flags_d = flags_exec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
    end
  end

  acc_alu_cond u_cond (
    .cond_sel   (cond_sel),
    .cond_bit   (cond_bit),
    .cond_check (cond_check),
    .flag_z     (flags_q[FL_Z]),
    .flag_n     (flags_q[FL_N]),
    .cond_true  (cond_true),
    .cond_err   (cond_err)
  );

  acc_alu_mul #(.DATA_W(DATA_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .mul_en  (mul_en),
    .mul_x   (mul_x),
    .mul_y   (mul_y),
    .product (product)
  );

  assign acc    = acc_q;
  assign status = {flags_q, {FLAG_LSB{1'b0}}};
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [3:0]        cond_sel,
  input logic              mul_en,
  input logic [ACC_W-1:0]  acc,
  input logic [15:0]       status,
  input logic [ACC_W-1:0]  product,
  input logic              cond_true,
  input logic              cond_err
);
  logic arith;
  assign arith = op_valid && (op_code == 4'd3 || op_code == 4'd4 || op_code == 4'd5);

  a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd5) |=> $stable(acc));

  a_r5_arith_lv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    arith |=> (status[12] == 1'b0 && status[14] == 1'b0));

  a_r5_zn_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> !(status[13] && status[15]));

  a_r6_and_clears_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd6) |=> (acc[DATA_W-1:0] == '0));

  a_r9_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd1 || op_code == 4'd2)) |=> $stable(status));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> ($stable(acc) && $stable(status)));

  a_r11_always_true: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'h0) |-> cond_true);

  a_r12_err_means_false: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |-> !cond_true);

  a_r13_product_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul_en) |=> $stable(product));
endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .cond_sel  (cond_sel),
  .mul_en    (mul_en),
  .acc       (acc),
  .status    (status),
  .product   (product),
  .cond_true (cond_true),
  .cond_err  (cond_err)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [15:0] operand;
  logic [3:0]  cond_sel;
  logic        cond_bit;
  logic        cond_check;
  logic        mul_en;
  logic [15:0] mul_x, mul_y;
  logic [31:0] acc;
  logic [15:0] status;
  logic [31:0] product;
  logic        cond_true, cond_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model; flags {N,V,Z,L}
  logic [31:0] m_acc;
  logic [3:0]  m_fl;
  logic [31:0] m_prod;

  always #2 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .cond_sel(cond_sel), .cond_bit(cond_bit),
    .cond_check(cond_check), .mul_en(mul_en), .mul_x(mul_x), .mul_y(mul_y),
    .acc(acc), .status(status), .product(product),
    .cond_true(cond_true), .cond_err(cond_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd1, 4'd2: return "R9";
      4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] mul_ref(input logic [15:0] x, input logic [15:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y)) * 2;
    return p[31:0];
  endfunction

  function automatic logic exp_cond(input logic [3:0] sel, input logic b, input logic [3:0] fl);
    if (sel == 4'h0) return 1'b1;
    if (sel == 4'h5) return fl[1] == b;
    if (sel == 4'h7) return fl[3] == b;
    return 1'b0;
  endfunction

  // model update for the inputs presented at the coming edge
  task automatic model_step();
    logic [15:0] hi, r16;
    logic [31:0] w, r32;
    hi = m_acc[31:16];
    w  = {operand, 16'h0};
    if (op_valid) begin
      case (op_code)
        4'd1: m_acc[31:16] = operand;
        4'd2: m_acc[15:0]  = operand;
        4'd3, 4'd4, 4'd5: begin
          r16 = (op_code == 4'd3) ? hi + operand : hi - operand;
          if (op_code != 4'd5) m_acc[31:16] = r16;
          m_fl = {(r16 != 0) && r16[15], 1'b0, r16 == 0, 1'b0};
        end
        4'd6, 4'd7, 4'd8: begin
          r32 = (op_code == 4'd6) ? (m_acc & w) : (op_code == 4'd7) ? (m_acc | w) : (m_acc ^ w);
          m_acc = r32;
          m_fl[1] = (r32 == 0);
          m_fl[3] = (r32 != 0) && r32[31];
        end
        default: ;
      endcase
    end
    if (mul_en) m_prod = mul_ref(mul_x, mul_y);
  endtask

  logic [3:0] last_op;

  // at negedge: check state from previous edge, drive new inputs, check cond
  task automatic step(input logic v, input logic [3:0] op, input logic [15:0] d,
                      input logic [3:0] cs, input logic cb, input logic me,
                      input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    check({op_tag(last_op), " acc"}, acc, m_acc);
    check({op_tag(last_op), " R5 R8 status"}, {16'h0, status}, {16'h0, m_fl, 12'h0});
    check("R13 product", product, m_prod);
    op_valid = v; op_code = op; operand = d;
    cond_sel = cs; cond_bit = cb; cond_check = 1'b1;
    mul_en = me; mul_x = x; mul_y = y;
    last_op = v ? op : 4'd0;
    #1;
    check("R11 R12 cond_true", {31'h0, cond_true}, {31'h0, exp_cond(cs, cb, m_fl)});
    check("R12 cond_err", {31'h0, cond_err},
          {31'h0, !(cs == 4'h0 || cs == 4'h5 || cs == 4'h7)});
    model_step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; operand = '0;
    cond_sel = 4'h0; cond_bit = 1'b0; cond_check = 1'b0;
    mul_en = 1'b0; mul_x = '0; mul_y = '0;
    m_acc = '0; m_fl = '0; m_prod = '0; last_op = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 acc", acc, 32'h0);
    check("R1 status", {16'h0, status}, 32'h0);
    check("R1 product", product, 32'h0);
    check("R1 cond_err", {31'h0, cond_err}, 32'h0);
    rst_n = 1'b1;

    // directed: add wrap to zero, N from bit 15, compare, subtract
    step(1, 4'd1, 16'hFFFF, 4'h5, 1'b1, 0, 0, 0);
    step(1, 4'd3, 16'h0001, 4'h5, 1'b1, 0, 0, 0);   // R2 wrap -> Z
    step(1, 4'd3, 16'h8000, 4'h5, 1'b1, 0, 0, 0);   // R5 Z seen as true
    step(1, 4'd5, 16'h8000, 4'h7, 1'b1, 0, 0, 0);   // R4 equal -> Z
    step(1, 4'd4, 16'h0001, 4'h5, 1'b1, 0, 0, 0);   // R3 -> 0x7FFF
    step(1, 4'd4, 16'h8000, 4'h7, 1'b0, 0, 0, 0);   // R3 -> 0xFFFF N
    // logic flags from full width: hi 0, low nonzero
    step(1, 4'd1, 16'h0000, 4'h7, 1'b1, 0, 0, 0);
    step(1, 4'd2, 16'h0005, 4'h0, 1'b0, 0, 0, 0);   // R9 low load
    step(1, 4'd7, 16'h0000, 4'h3, 1'b0, 0, 0, 0);   // R8 OR 0 -> not Z
    step(1, 4'd8, 16'h8000, 4'h5, 1'b0, 0, 0, 0);   // R7 XOR keeps low
    step(1, 4'd6, 16'h7FFF, 4'h7, 1'b1, 0, 0, 0);   // R6 AND -> zero
    step(0, 4'd3, 16'h1234, 4'h5, 1'b1, 0, 0, 0);   // R10 idle
    step(1, 4'd9, 16'h1234, 4'hF, 1'b0, 0, 0, 0);   // R10 undefined op
    // R13 corners
    step(0, 4'd0, 0, 4'h0, 0, 1, 16'h8000, 16'h8000);
    step(0, 4'd0, 0, 4'h0, 0, 1, 16'h0003, 16'hFFFE);
    step(0, 4'd0, 0, 4'h0, 0, 0, 16'h1111, 16'h2222);

    for (int i = 0; i < 1500; i++) begin
      logic [3:0] cs;
      int pick;
      pick = $urandom_range(0, 4);
      cs = (pick == 0) ? 4'h0 : (pick == 1) ? 4'h5 : (pick == 2) ? 4'h7 : 4'($urandom);
      step(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 10)),
           ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom),
           cs, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end
    step(0, 4'd0, 0, 4'h0, 0, 0, 0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule